// File: doc/BRIEF.md
# Spare-Area Status Byte Stripper

This block filters the byte stream that carries spare-area (out-of-band) data back from an ECC engine on a page read. The engine appends a four-byte status group after every chunk's spare bytes. The block forwards only the spare bytes, in arrival order, so the downstream consumer sees a packed spare buffer. In that buffer, chunk k starts at byte k × step, and nothing is left where the status groups stood. Each chunk covers 1 KiB of main data, so the per-chunk spare step is the page's spare size divided by the chunk count.

Only the first byte of each status group carries meaning. The block latches that byte and presents it on a separate status port, tagged with its chunk index. It then swallows the remaining three bytes without looking at them. Both the input and the spare output use valid/ready handshakes. The block accepts the four status bytes whether or not the spare output is stalled. After the status group of the last chunk has been consumed, it raises an end-of-page pulse and re-arms for the next page.

Control is a three-state machine:
- `ST_SPARE` forwards spare bytes. It moves to `ST_STAT` when the chunk's last spare byte is accepted.
- `ST_STAT` latches the status byte. It moves to `ST_PAD` on acceptance.
- `ST_PAD` discards three bytes. It returns to `ST_SPARE` on the third byte. If that byte ends the last chunk, the move is the page-wrap transition: the chunk counter clears and `page_done` fires.

Top module: `spare_stat_strip`

## Requirements
- R1: After reset the block is in the spare-forwarding state. `out_valid`, `stat_valid` and `page_done` are 0, and `in_ready` equals `out_ready`.
- R2: Spare bytes pass through unchanged and in order. The output spare byte at position k × `cfg_step_len` + j is input byte j of chunk k, with no gaps between chunks.
- R3: The byte accepted right after a chunk's `cfg_step_len` spare bytes is that chunk's status. It appears on `stat_data`, with `stat_chunk` = k, for exactly one cycle with `stat_valid` high, in the cycle after it is accepted.
- R4: The three bytes following each status byte are consumed and dropped whatever their value. Neither they nor the status byte ever appear on `out_data` with `out_valid`.
- R5: While a status or discard byte is being taken, `in_ready` is 1 even when `out_ready` is 0, and `out_valid` is 0. While spare bytes flow, `in_ready` follows `out_ready` and `out_valid` follows `in_valid`.
- R6: `page_done` is a one-cycle pulse in the cycle after the last discard byte of the last chunk is accepted. It never coincides with `stat_valid`. The next accepted byte is spare byte 0 of chunk 0 of a new page.
- R7: One page consumes exactly `cfg_chunks` × (`cfg_step_len` + 4) input bytes and emits `cfg_chunks` × `cfg_step_len` spare bytes and `cfg_chunks` status bytes.
- R8: Every step length from 1 to 2^STEP_W − 1 and every chunk count from 1 to 2^CHUNK_W − 1 is handled, including a step of one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_step_len | input | STEP_W | Spare bytes per chunk (≥ 1) |
| cfg_chunks | input | CHUNK_W | Chunks per page (≥ 1) |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte from the engine |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| out_valid | output | 1 | Spare output byte valid |
| out_data | output | 8 | Spare output byte |
| out_ready | input | 1 | Downstream accepts spare byte |
| stat_valid | output | 1 | One-cycle strobe for a captured status byte |
| stat_data | output | 8 | Captured status byte |
| stat_chunk | output | CHUNK_W | Chunk index of the captured status |
| page_done | output | 1 | One-cycle end-of-page pulse |

## Verification
The assertions take for granted that `cfg_step_len` and `cfg_chunks` are nonzero and stay constant while a page is in flight, and that the input stream follows the chunk layout. Given that layout, at least four accepted bytes separate successive status strobes and the end-of-page pulse. The stimulus changes configuration only between pages, once `page_done` has been seen and the input is idle. It builds every page from the exact layout for the configured step and chunk count. Stalls on the spare output and gaps on the input are varied independently, so the handshake rules are exercised without breaking the layout.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
    localparam int BYTE_W      = 8;
    localparam int STAT_GROUP  = 4;
    localparam int DISCARD_CNT = STAT_GROUP - 1;

    typedef enum logic [1:0] {
        ST_SPARE = 2'd0,
        ST_STAT  = 2'd1,
        ST_PAD   = 2'd2
    } strip_state_e;
endpackage

// File: rtl/ssb_ctr.sv
module ssb_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] lim,
    output logic [W-1:0] cnt,
    output logic         at_end
);
    assign at_end = (cnt == lim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= at_end ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spare_stat_strip.sv
module spare_stat_strip
    import ssb_pkg::*;
#(
    parameter int STEP_W  = 8,
    parameter int CHUNK_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STEP_W-1:0]  cfg_step_len,
    input  logic [CHUNK_W-1:0] cfg_chunks,
    input  logic               in_valid,
    input  logic [BYTE_W-1:0]  in_data,
    output logic               in_ready,
    output logic               out_valid,
    output logic [BYTE_W-1:0]  out_data,
    input  logic               out_ready,
    output logic               stat_valid,
    output logic [BYTE_W-1:0]  stat_data,
    output logic [CHUNK_W-1:0] stat_chunk,
    output logic               page_done
);
    localparam int PAD_W = $clog2(DISCARD_CNT + 1);
    localparam logic [PAD_W-1:0] PAD_LAST = PAD_W'(DISCARD_CNT - 1);

    strip_state_e state, nxt;

    logic               byte_en, pad_en, chunk_en, cap;
    logic               byte_end, pad_end, chunk_end;
    logic [STEP_W-1:0]  byte_cnt;
    logic [PAD_W-1:0]   pad_cnt;
    logic [CHUNK_W-1:0] chunk_cnt;

    ssb_ctr #(.W(STEP_W)) u_byte_ctr (
        .clk(clk), .rst_n(rst_n), .en(byte_en),
        .lim(cfg_step_len - 1'b1), .cnt(byte_cnt), .at_end(byte_end)
    );

    ssb_ctr #(.W(PAD_W)) u_pad_ctr (
        .clk(clk), .rst_n(rst_n), .en(pad_en),
        .lim(PAD_LAST), .cnt(pad_cnt), .at_end(pad_end)
    );

    ssb_ctr #(.W(CHUNK_W)) u_chunk_ctr (
        .clk(clk), .rst_n(rst_n), .en(chunk_en),
        .lim(cfg_chunks - 1'b1), .cnt(chunk_cnt), .at_end(chunk_end)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SPARE;
        else        state <= nxt;
    end

    // Next state and handshake outputs
    always_comb begin
        nxt       = state;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        byte_en   = 1'b0;
        pad_en    = 1'b0;
        cap       = 1'b0;
        unique case (state)
            ST_SPARE: begin
                out_valid = in_valid;
                in_ready  = out_ready;
                if (in_valid && out_ready) begin
                    byte_en = 1'b1;
                    if (byte_end) nxt = ST_STAT;
                end
            end
            ST_STAT: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    cap = 1'b1;
                    nxt = ST_PAD;
                end
            end
            ST_PAD: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    pad_en = 1'b1;
                    if (pad_end) nxt = ST_SPARE;
                end
            end
            default: nxt = ST_SPARE;
        endcase
    end

    assign chunk_en = pad_en && pad_end;
    assign out_data = in_data;

    // Registered status port and end-of-page pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_valid <= 1'b0;
            stat_data  <= '0;
            stat_chunk <= '0;
            page_done  <= 1'b0;
        end else begin
            stat_valid <= cap;
            page_done  <= chunk_en && chunk_end;
            if (cap) begin
                stat_data  <= in_data;
                stat_chunk <= chunk_cnt;
            end
        end
    end

    logic unused_ok;
    assign unused_ok = ^{byte_cnt, pad_cnt};
endmodule

// File: rtl/ssb_checker.sv
module ssb_checker #(
    parameter int CHUNK_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic               stat_valid,
    input logic [CHUNK_W-1:0] stat_chunk,
    input logic               page_done
);
    a_r2_no_invented_byte: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_valid);

    a_r3_stat_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid);

    a_r3_stat_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> $past(in_valid && in_ready));

    a_r4_no_emit_after_stat: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> !out_valid);

    a_r5_stall_free_consume: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !out_ready) |-> !out_valid);

    a_r6_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |=> !page_done);

    a_r6_done_apart_from_stat: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |-> !stat_valid);

    a_r6_done_after_input: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |-> $past(in_valid && in_ready));

    logic unused_chk;
    assign unused_chk = ^stat_chunk;
endmodule

bind spare_stat_strip ssb_checker #(.CHUNK_W(CHUNK_W)) u_ssb_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .stat_valid(stat_valid),
    .stat_chunk(stat_chunk), .page_done(page_done)
);

// File: tb/spare_stat_strip_bench.sv
module spare_stat_strip_bench;
    localparam int STEP_W  = 4;
    localparam int CHUNK_W = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [STEP_W-1:0]  cfg_step_len = 4'd1;
    logic [CHUNK_W-1:0] cfg_chunks = 2'd1;
    logic               in_valid = 1'b0;
    logic [7:0]         in_data = 8'd0;
    logic               in_ready;
    logic               out_valid;
    logic [7:0]         out_data;
    logic               out_ready = 1'b1;
    logic               stat_valid;
    logic [7:0]         stat_data;
    logic [CHUNK_W-1:0] stat_chunk;
    logic               page_done;

    int n_tests = 0;
    int n_fail  = 0;
    int page_no = 0;

    always #10 clk = ~clk;

    spare_stat_strip #(.STEP_W(STEP_W), .CHUNK_W(CHUNK_W)) u_spare_stat_strip (
        .clk(clk), .rst_n(rst_n), .cfg_step_len(cfg_step_len), .cfg_chunks(cfg_chunks),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .stat_valid(stat_valid), .stat_data(stat_data), .stat_chunk(stat_chunk),
        .page_done(page_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] spare_byte(input int k, input int j, input int pg);
        return 8'(k * 53 + j * 7 + pg * 11 + 3);
    endfunction

    function automatic logic [7:0] stat_byte(input int k, input int pg);
        return 8'(8'h10 + k * 9 + pg * 5);
    endfunction

    function automatic logic [7:0] stream_byte(input int i, input int step, input int pg);
        int grp = step + 4;
        int k = i / grp;
        int r = i % grp;
        if (r < step)       return spare_byte(k, r, pg);
        else if (r == step) return stat_byte(k, pg);
        else                return 8'(8'hF0 ^ (k * 3 + r + pg));
    endfunction

    task automatic run_page(input int step, input int chunks, input int mode);
        int total = chunks * (step + 4);
        int idx = 0, out_cnt = 0, stat_cnt = 0, cyc = 0;
        bit done_seen = 0;
        cfg_step_len = STEP_W'(step);
        cfg_chunks   = CHUNK_W'(chunks);
        while (!done_seen && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (stat_valid) begin
                chk(stat_data == stat_byte(stat_cnt, page_no), "R3 stat_data",
                    int'(stat_data), int'(stat_byte(stat_cnt, page_no)));
                chk(int'(stat_chunk) == stat_cnt, "R3 stat_chunk", int'(stat_chunk), stat_cnt);
                chk(!out_valid, "R4 no spare with status strobe", int'(out_valid), 0);
                stat_cnt++;
            end
            if (page_done) begin
                done_seen = 1;
                chk(!stat_valid, "R6 done apart from status", int'(stat_valid), 0);
                chk(idx == total, "R7 input bytes per page", idx, total);
                chk(out_cnt == chunks * step, "R7 spare bytes per page", out_cnt, chunks * step);
                chk(stat_cnt == chunks, "R7 status bytes per page", stat_cnt, chunks);
            end
            in_valid  = (idx < total) && !(mode == 1 && (cyc % 4) == 0);
            in_data   = stream_byte(idx, step, page_no);
            out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? 1'(cyc % 2) : 1'((cyc % 3) == 0);
            #1;
            if (in_valid && (idx % (step + 4)) >= step) begin
                chk(in_ready == 1'b1, "R5 ready during status bytes", int'(in_ready), 1);
                chk(out_valid == 1'b0, "R4 status bytes withheld", int'(out_valid), 0);
            end else if (in_valid) begin
                chk(in_ready == out_ready, "R5 ready follows output", int'(in_ready), int'(out_ready));
            end
            if (out_valid && out_ready) begin
                chk(out_data == spare_byte(out_cnt / step, out_cnt % step, page_no),
                    "R2 spare byte order", int'(out_data),
                    int'(spare_byte(out_cnt / step, out_cnt % step, page_no)));
                out_cnt++;
            end
            if (in_valid && in_ready) idx++;
        end
        chk(done_seen, "R6 end-of-page pulse seen", int'(done_seen), 1);
        @(negedge clk);
        chk(!page_done, "R6 done single cycle", int'(page_done), 0);
        page_no++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!out_valid, "R1 reset out_valid", int'(out_valid), 0);
        chk(!stat_valid, "R1 reset stat_valid", int'(stat_valid), 0);
        chk(!page_done, "R1 reset page_done", int'(page_done), 0);
        chk(in_ready == out_ready, "R1 reset spare state", int'(in_ready), int'(out_ready));
        // R8: sweep step lengths including 1 and the maximum, every chunk count
        foreach (step_list[si]) begin
            for (int c = 1; c <= 3; c++) begin
                for (int m = 0; m < 3; m++) begin
                    run_page(step_list[si], c, m);
                end
            end
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    int step_list[5] = '{1, 2, 3, 7, 15};

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule